// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle Preamble

This block turns words written by software into an asynchronous serial bit stream on a single line. A one-word holding register accepts a write while it is empty; a frame sequencer moves the word into its shift register on a baud-tick boundary and sends a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts one baud-tick interval. Words are 8 bits (`wr_data[7:0]`) when `word9` is 0, or 9 bits (`wr_data[8:0]`) when `word9` is 1. The frame length NB is therefore 10 or 11 bit times.

Software watches two flags. `txe` reports that the holding register is free, and `tc` reports that the line has gone quiet with nothing queued. When the transmitter is first enabled, it sends one all-ones frame of NB bit times before any data. A break request is queued: after the frame in progress, the line goes low for NB bit times and is then held high for two bit times.

The sequencer states are OFF (disabled, line high), PREAMBLE (idle frame), READY (enabled, nothing to send), FRAME (shifting a word), BREAK (low period) and BRKSTOP (two high bits). Transitions happen only on a baud tick. OFF goes to PREAMBLE when `tx_en` is high. PREAMBLE, FRAME and BRKSTOP each end after their last bit. At that point, and on every tick in READY, the sequencer dispatches in this order: to OFF if `tx_en` is low, to BREAK if a break is pending, to FRAME (loading the holding register) if a word waits, and otherwise to READY. BREAK always goes to BRKSTOP after its last low bit.

Top module: `serial_tx_core`

## Requirements
- R1: After reset `txd`=1, `txe`=1, `tc`=1, `brk_pend`=0 and `wr_ovr`=0.
- R2: After `tx_en` is raised, the first baud tick starts NB high bit times before any frame is sent.
- R3: A frame is a 0 start bit, the data bits LSB first, then a 1 stop bit, one bit per baud-tick interval. There are 8 data bits from `wr_data[7:0]` when `word9`=0 and 9 from `wr_data[8:0]` when `word9`=1.
- R4: An accepted write clears `txe` on the next clock. `txe` returns to 1 in the cycle after the word moves into the shift register, which happens on a baud tick.
- R5: If a word is waiting when a frame ends, its start bit follows the previous stop bit with no gap, and `tc` stays 0.
- R6: `tc` is set at the end of a frame when `txe` is 1. It is cleared by an accepted write or by a `tc_clr` pulse.
- R7: A break request waits for the current frame to finish. The line is then low for NB bit times and high for two bit times.
- R8: `brk_pend` rises on the clock after `brk_req`. It falls when the break's low period ends, at the start of its two high bits.
- R9: A write while `txe`=0 is dropped and never appears on the line, and `wr_ovr` becomes 1 and stays 1 until reset.
- R10: When a break is pending and a word is also waiting at a frame end, the break is sent first and the word follows right after the break's high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmitter enable |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| tc_clr | input | 1 | Clears the transmission-complete flag |
| brk_req | input | 1 | Requests a break character |
| txd | output | 1 | Serial line, idles high |
| txe | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| brk_pend | output | 1 | Break requested and not yet finished |
| wr_ovr | output | 1 | Sticky flag for a write dropped while full |

## Verification
A wrong bit counter or a wrong shift-register fill shows up on `txd` within one frame. It appears as a start bit at the wrong place, a shortened preamble or break, or a missing stop bit, and the scoreboard catches it on the first bad bit interval. A wrong dispatch decision surfaces at the next frame boundary: a gap between back-to-back frames, data sent ahead of a pending break, or a dropped word replayed. Flag faults in `txe`, `tc` and `brk_pend` are visible one clock after the write, load or break end that should move them. The bench samples them at those points.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRE,
        ST_READY,
        ST_FRAME,
        ST_BREAK,
        ST_BSTOP
    } tx_state_e;
endpackage

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          tc_clr,
    input  logic          brk_req,
    input  logic          load,
    input  logic          frame_done,
    input  logic          brk_done,
    output logic [DW-1:0] hold_q,
    output logic          txe,
    output logic          tc,
    output logic          brk_pend,
    output logic          wr_ovr
);
    logic wr_acc;
    assign wr_acc = wr_en && txe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            txe      <= 1'b1;
            tc       <= 1'b1;
            brk_pend <= 1'b0;
            wr_ovr   <= 1'b0;
        end else begin
            if (wr_acc) begin
                hold_q <= wr_data;
                txe    <= 1'b0;
            end else if (load) begin
                txe    <= 1'b1;
            end
            if (wr_acc || tc_clr)
                tc <= 1'b0;
            else if (frame_done && txe)
                tc <= 1'b1;
            if (brk_req)
                brk_pend <= 1'b1;
            else if (brk_done)
                brk_pend <= 1'b0;
            if (wr_en && !txe)
                wr_ovr <= 1'b1;
        end
    end

    assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !txe);
    assert_load_frees_holding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> txe);
    assert_break_request_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> brk_pend);
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovr |=> wr_ovr);
endmodule

// File: rtl/serial_tx_seq.sv
module serial_tx_seq
    import serial_tx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          word9,
    input  logic          hold_empty,
    input  logic [DW-1:0] hold_q,
    input  logic          brk_pend,
    output logic          load,
    output logic          frame_done,
    output logic          brk_done,
    output logic          txd
);
    localparam int FW = DW + 2;
    localparam int CW = $clog2(FW + 1);

    tx_state_e       state, nxt, disp;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   nbits;
    logic [FW-1:0]   shreg;
    logic [FW-1:0]   load_vec;
    logic            at_last;
    logic            disp_load;

    assign nbits    = word9 ? CW'(FW) : CW'(FW - 1);
    assign at_last  = (cnt == nbits - 1'b1);
    assign load_vec = word9 ? {1'b1, hold_q, 1'b0}
                            : {2'b11, hold_q[DW-2:0], 1'b0};

    always_comb begin
        disp_load = 1'b0;
        if (!tx_en)
            disp = ST_OFF;
        else if (brk_pend)
            disp = ST_BREAK;
        else if (!hold_empty) begin
            disp      = ST_FRAME;
            disp_load = 1'b1;
        end else
            disp = ST_READY;
    end

    always_comb begin
        nxt        = state;
        load       = 1'b0;
        frame_done = 1'b0;
        brk_done   = 1'b0;
        if (baud_tick) begin
            unique case (state)
                ST_OFF:   if (tx_en) nxt = ST_PRE;
                ST_PRE:   if (at_last) begin
                              nxt  = disp;
                              load = disp_load;
                          end
                ST_READY: begin
                              nxt  = disp;
                              load = disp_load;
                          end
                ST_FRAME: if (at_last) begin
                              frame_done = 1'b1;
                              nxt        = disp;
                              load       = disp_load;
                          end
                ST_BREAK: if (at_last) begin
                              nxt      = ST_BSTOP;
                              brk_done = 1'b1;
                          end
                ST_BSTOP: if (cnt == CW'(1)) begin
                              nxt  = disp;
                              load = disp_load;
                          end
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '1;
        end else if (baud_tick) begin
            if (nxt != state || load)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (load)
                shreg <= load_vec;
            else if (state == ST_FRAME)
                shreg <= {1'b1, shreg[FW-1:1]};
        end
    end

    always_comb begin
        unique case (state)
            ST_FRAME: txd = shreg[0];
            ST_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    assert_load_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !hold_empty);
    assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && tx_en && !brk_pend && !hold_empty) |-> load);
    assert_break_tail_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |=> txd);
    assert_break_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && tx_en && brk_pend) |-> !load);
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          word9,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          tc_clr,
    input  logic          brk_req,
    output logic          txd,
    output logic          txe,
    output logic          tc,
    output logic          brk_pend,
    output logic          wr_ovr
);
    logic [DW-1:0] hold_q;
    logic          load, frame_done, brk_done;

    serial_tx_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tc_clr     (tc_clr),
        .brk_req    (brk_req),
        .load       (load),
        .frame_done (frame_done),
        .brk_done   (brk_done),
        .hold_q     (hold_q),
        .txe        (txe),
        .tc         (tc),
        .brk_pend   (brk_pend),
        .wr_ovr     (wr_ovr)
    );

    serial_tx_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_en      (tx_en),
        .word9      (word9),
        .hold_empty (txe),
        .hold_q     (hold_q),
        .brk_pend   (brk_pend),
        .load       (load),
        .frame_done (frame_done),
        .brk_done   (brk_done),
        .txd        (txd)
    );
endmodule

// File: tb/sim_serial_tx_core.sv
module sim_serial_tx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       word9 = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tc_clr = 1'b0;
    logic       brk_req = 1'b0;
    logic       txd, txe, tc, brk_pend, wr_ovr;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  exp_q[$];
    bit  exp_bit;
    int  tick_cnt = 0;

    serial_tx_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .word9(word9), .wr_en(wr_en), .wr_data(wr_data), .tc_clr(tc_clr),
        .brk_req(brk_req), .txd(txd), .txe(txe), .tc(tc),
        .brk_pend(brk_pend), .wr_ovr(wr_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == TICK_DIV-2);
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard monitor: one line level per bit interval (R2 R3 R5 R7 R9 R10)
    always begin
        @(posedge clk iff baud_tick);
        #1;
        if (rst_n) begin
            exp_bit = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
            check("R3 line bit", int'(txd), int'(exp_bit));
        end
    end

    task automatic wait_tick();
        @(posedge clk iff baud_tick);
        #3;
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    task automatic push_ones(int n);
        for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
    endtask

    task automatic push_break(int nb);
        for (int i = 0; i < nb; i++) exp_q.push_back(1'b0);
        push_ones(2);
    endtask

    task automatic push_frame(logic [8:0] d, bit w9);
        exp_q.push_back(1'b0);
        for (int i = 0; i < (w9 ? 9 : 8); i++) exp_q.push_back(d[i]);
        exp_q.push_back(1'b1);
    endtask

    task automatic write_word(logic [8:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) wait_tick();
        wait_ticks(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check("R1 txd", int'(txd), 1);
        check("R1 txe", int'(txe), 1);
        check("R1 tc", int'(tc), 1);
        check("R1 brk_pend", int'(brk_pend), 0);
        check("R1 wr_ovr", int'(wr_ovr), 0);
        rst_n = 1'b1;
        wait_ticks(3);

        // R2 preamble, then first 8-bit frame (R3, R4)
        tx_en = 1'b1;
        push_ones(10);
        write_word(9'h0A5);
        push_frame(9'h0A5, 1'b0);
        check("R4 txe cleared by write", int'(txe), 0);
        check("R6 tc cleared by write", int'(tc), 0);
        wait_ticks(11);
        check("R4 txe set after load", int'(txe), 1);
        drain();
        check("R6 tc set at frame end", int'(tc), 1);

        // R5 back to back frames
        write_word(9'h03C);
        push_frame(9'h03C, 1'b0);
        wait_tick();
        write_word(9'h0C3);
        push_frame(9'h0C3, 1'b0);
        wait_ticks(10);
        check("R5 tc stays clear between frames", int'(tc), 0);
        drain();
        check("R6 tc after last frame", int'(tc), 1);

        // R9 overrun
        write_word(9'h011);
        push_frame(9'h011, 1'b0);
        wait_tick();
        write_word(9'h022);
        push_frame(9'h022, 1'b0);
        write_word(9'h033);
        check("R9 overrun flag", int'(wr_ovr), 1);
        drain();
        check("R9 overrun sticky", int'(wr_ovr), 1);

        // R6 explicit clear
        tc_clr = 1'b1;
        @(posedge clk);
        #1;
        tc_clr = 1'b0;
        check("R6 tc_clr", int'(tc), 0);
        wait_ticks(3);
        check("R6 tc stays clear when idle", int'(tc), 0);

        // R7 R8 R10 break during frame with word waiting
        write_word(9'h05A);
        push_frame(9'h05A, 1'b0);
        wait_ticks(2);
        brk_req = 1'b1;
        @(posedge clk);
        #1;
        brk_req = 1'b0;
        push_break(10);
        check("R8 brk_pend set", int'(brk_pend), 1);
        write_word(9'h00F);
        push_frame(9'h00F, 1'b0);
        wait_ticks(18);
        check("R8 brk_pend held in low period", int'(brk_pend), 1);
        wait_tick();
        check("R8 brk_pend cleared at stop bits", int'(brk_pend), 0);
        drain();
        check("R10 tc after trailing word", int'(tc), 1);

        // R3 nine-bit mode, R7 nine-bit break from idle
        word9 = 1'b1;
        wait_tick();
        write_word(9'h1A5);
        push_frame(9'h1A5, 1'b1);
        drain();
        brk_req = 1'b1;
        @(posedge clk);
        #1;
        brk_req = 1'b0;
        push_break(11);
        drain();
        check("R8 brk_pend clear after 9-bit break", int'(brk_pend), 0);
        write_word(9'h0F3);
        push_frame(9'h0F3, 1'b1);
        drain();
        check("R6 tc after 9-bit frame", int'(tc), 1);

        finish_run();
    end
endmodule